// File: doc/BRIEF.md
# Dual-Mode Tick Timer

A timer made of two 8-bit counter halves, high and low, that advance on a clock-enable tick. When the mode input is low, the halves run as two independent 8-bit counters. When it is high, they form one cascaded 16-bit counter in which the high byte advances on the low byte's carry. Each half has its own compare register. Each half also has a compare-match flag, an overflow flag, an overflow interrupt enable and a clear-on-match enable. All of the flags and enables sit in a single 8-bit control/status register (CSR) on a simple synchronous register bus. Read data is combinational from the address. Read and write strobes take effect at the clock edge.

Every status flag is held by its own small state machine with three states: `FLG_CLEAR` (flag 0), `FLG_SET` (flag 1, not yet seen by software) and `FLG_ARMED` (flag 1, and software has read the CSR while it was 1). The transitions are named as follows:
- **T_SET** (`FLG_CLEAR`→`FLG_SET`) occurs on a set event.
- **T_ARM** (`FLG_SET`→`FLG_ARMED`) occurs on a CSR read.
- **T_CLEAR** (`FLG_ARMED`→`FLG_CLEAR`) occurs on a CSR write with a 0 in the flag's bit and no set event in the same cycle.
- **T_DISARM** (`FLG_ARMED`→`FLG_SET`) occurs on a CSR write that writes a 1 to the flag's bit, or that coincides with a set event.

A CSR write always uses up the armed state. The interrupt outputs are levels: for each half, the overflow flag ANDed with that half's overflow enable.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, the CSR, both compare registers and both counter bytes read 0, and both interrupt outputs are low.
- R2: With `mode_i`=0, each counter byte increments by 1 (modulo 256) on every cycle with `tick_i`=1, independently of the other byte, and holds while `tick_i`=0.
- R3: With `mode_i`=1, the low byte increments on every tick. The high byte increments only on a tick where the low byte goes from 0xFF to 0x00.
- R4: A half's overflow flag sets on a tick where that half's counter goes from 0xFF to 0x00. The high-overflow flag is CSR bit 7 and the low-overflow flag is bit 3. In mode 1, the high byte counts as rolling over only when all 16 bits roll over.
- R5: A half's compare flag sets on a tick where that half's counter equals its compare register. The high-compare flag is CSR bit 6 and the low-compare flag is bit 2. In mode 1, the high flag requires both bytes to equal their compare registers.
- R6: A flag clears only on a CSR write that has a 0 in its bit, made after a CSR read that saw the flag at 1. Writing 1 has no effect, and a write of 0 without that earlier read has no effect. Any CSR write uses up the earlier read.
- R7: If a flag's set event and a valid clearing write fall in the same cycle, the flag stays 1.
- R8: CSR bits 5 (high overflow interrupt enable), 4 (high clear-on-match), 1 (low overflow interrupt enable) and 0 (low clear-on-match) are plain read/write bits.
- R9: `irq_hi_o` is the level of CSR bit 7 AND bit 5, and `irq_lo_o` is the level of CSR bit 3 AND bit 1.
- R10: With bit 0 set, a tick on which the low byte equals its compare register loads the low byte with 0 instead of incrementing it.
- R11: With bit 4 set, a high-half compare match on a tick clears only the high byte when `mode_i`=0, and clears all 16 bits when `mode_i`=1.
- R12: Bus addresses: 0 is the CSR, 1 is the high compare register, 2 is the low compare register, 3 is the high counter byte (read only) and 4 is the low counter byte (read only). Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one step per cycle when high |
| mode_i | input | 1 | 0: two 8-bit counters, 1: one 16-bit counter |
| bus_addr_i | input | 3 | Register address |
| bus_rd_i | input | 1 | Read strobe (arms flags read as 1 when the address is the CSR) |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| irq_hi_o | output | 1 | High-half overflow interrupt request level |
| irq_lo_o | output | 1 | Low-half overflow interrupt request level |

## Verification
The assertions check the following on every cycle:
- the counter holds between ticks, and increments by one in split mode;
- the high byte stays still without a carry in cascaded mode;
- both clear variants of the high clear enable behave as specified;
- a set event always leaves its flag at 1;
- a flag can fall only from the armed state under a 0 write;
- the enable bits are written back as given.

Only the bench scenarios can show the following:
- the full read-then-write protocol, including a write of 0 with no earlier read, a write of 1, and an armed state used up by an earlier write;
- a set event that collides with a clearing write;
- the 16-bit rollover after 65536 ticks;
- the compare periods produced by sweeps over several compare values in both modes.

// File: rtl/dtt_pkg.sv
`timescale 1ns/100ps
package dtt_pkg;
    localparam int HALF_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int NUM_FLAGS = 4;

    localparam logic [ADDR_W-1:0] A_CSR    = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd4;

    // CSR positions of the enable bits
    localparam int B_OVIE_HI = 5;
    localparam int B_CCLR_HI = 4;
    localparam int B_OVIE_LO = 1;
    localparam int B_CCLR_LO = 0;

    typedef enum logic [1:0] {FLG_CLEAR, FLG_SET, FLG_ARMED} flag_state_e;

    // flag index 0: hi overflow, 1: hi compare, 2: lo overflow, 3: lo compare
    function automatic int flag_pos(input int idx);
        case (idx)
            0:       return 7;
            1:       return 6;
            2:       return 3;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/dtt_flag_fsm.sv
`timescale 1ns/100ps
module dtt_flag_fsm
    import dtt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: if (set_evt_i) state_d = FLG_SET;            // T_SET
            FLG_SET:   if (rd_i)      state_d = FLG_ARMED;          // T_ARM
            FLG_ARMED: if (wr_i)      state_d = (!wbit_i && !set_evt_i)
                                                ? FLG_CLEAR         // T_CLEAR
                                                : FLG_SET;          // T_DISARM
            default:                  state_d = FLG_CLEAR;
        endcase
    end

    always_comb flag_o = (state_q != FLG_CLEAR);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt_i |=> flag_o);

    assert_clear_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(state_q == FLG_ARMED && wr_i && !wbit_i));
endmodule

// File: rtl/dtt_counter_pair.sv
`timescale 1ns/100ps
module dtt_counter_pair #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         mode_i,
    input  logic [W-1:0] cmp_hi_i,
    input  logic [W-1:0] cmp_lo_i,
    input  logic         clr_en_hi_i,
    input  logic         clr_en_lo_i,
    output logic [W-1:0] cnt_hi_o,
    output logic [W-1:0] cnt_lo_o,
    output logic         ovf_evt_hi_o,
    output logic         ovf_evt_lo_o,
    output logic         cmp_evt_hi_o,
    output logic         cmp_evt_lo_o
);
    localparam logic [W-1:0] ONE_V  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] FULL_V = {W{1'b1}};

    logic [W-1:0] lo_d, hi_d;
    logic lo_hit, hi_hit, wide_hit, hi_match, lo_full, hi_full, carry;

    always_comb begin
        lo_hit   = (cnt_lo_o == cmp_lo_i);
        hi_hit   = (cnt_hi_o == cmp_hi_i);
        wide_hit = lo_hit && hi_hit;
        hi_match = mode_i ? wide_hit : hi_hit;
        lo_full  = (cnt_lo_o == FULL_V);
        hi_full  = (cnt_hi_o == FULL_V);
        carry    = mode_i ? lo_full : 1'b1;
    end

    always_comb begin
        lo_d = cnt_lo_o;
        hi_d = cnt_hi_o;
        if (tick_i) begin
            lo_d = (clr_en_lo_i && lo_hit) ? '0 : cnt_lo_o + ONE_V;
            if (carry) hi_d = cnt_hi_o + ONE_V;
            if (clr_en_hi_i && hi_match) begin
                hi_d = '0;
                if (mode_i) lo_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_lo_o <= '0;
            cnt_hi_o <= '0;
        end else begin
            cnt_lo_o <= lo_d;
            cnt_hi_o <= hi_d;
        end
    end

    always_comb begin
        ovf_evt_lo_o = tick_i && lo_full;
        ovf_evt_hi_o = tick_i && carry && hi_full;
        cmp_evt_lo_o = tick_i && lo_hit;
        cmp_evt_hi_o = tick_i && hi_match;
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(cnt_lo_o) && $stable(cnt_hi_o)));

    assert_split_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !mode_i && !(clr_en_lo_i && lo_hit))
        |=> cnt_lo_o == $past(cnt_lo_o) + ONE_V);

    assert_casc_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_i && !lo_full && !(clr_en_hi_i && wide_hit))
        |=> $stable(cnt_hi_o));

    assert_wide_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_i && clr_en_hi_i && wide_hit)
        |=> (cnt_hi_o == '0 && cnt_lo_o == '0));

    assert_split_hi_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !mode_i && clr_en_hi_i && hi_hit && !(clr_en_lo_i && lo_hit))
        |=> (cnt_hi_o == '0 && cnt_lo_o == $past(cnt_lo_o) + ONE_V));
endmodule

// File: rtl/dual_tick_timer.sv
`timescale 1ns/100ps
module dual_tick_timer
    import dtt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [HALF_W-1:0] bus_wdata_i,
    output logic [HALF_W-1:0] bus_rdata_o,
    output logic              irq_hi_o,
    output logic              irq_lo_o
);
    logic [HALF_W-1:0] cmp_hi_q, cmp_lo_q, cnt_hi, cnt_lo, csr;
    logic ovie_hi_q, cclr_hi_q, ovie_lo_q, cclr_lo_q;
    logic ovf_hi_evt, ovf_lo_evt, cmp_hi_evt, cmp_lo_evt;
    logic [NUM_FLAGS-1:0] set_evt, flag;
    logic csr_rd, csr_wr;

    always_comb begin
        csr_rd = bus_rd_i && (bus_addr_i == A_CSR);
        csr_wr = bus_wr_i && (bus_addr_i == A_CSR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_hi_q  <= '0;
            cmp_lo_q  <= '0;
            ovie_hi_q <= 1'b0;
            cclr_hi_q <= 1'b0;
            ovie_lo_q <= 1'b0;
            cclr_lo_q <= 1'b0;
        end else if (bus_wr_i) begin
            if (bus_addr_i == A_CMP_HI) cmp_hi_q <= bus_wdata_i;
            if (bus_addr_i == A_CMP_LO) cmp_lo_q <= bus_wdata_i;
            if (csr_wr) begin
                ovie_hi_q <= bus_wdata_i[B_OVIE_HI];
                cclr_hi_q <= bus_wdata_i[B_CCLR_HI];
                ovie_lo_q <= bus_wdata_i[B_OVIE_LO];
                cclr_lo_q <= bus_wdata_i[B_CCLR_LO];
            end
        end
    end

    dtt_counter_pair #(.W(HALF_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .mode_i       (mode_i),
        .cmp_hi_i     (cmp_hi_q),
        .cmp_lo_i     (cmp_lo_q),
        .clr_en_hi_i  (cclr_hi_q),
        .clr_en_lo_i  (cclr_lo_q),
        .cnt_hi_o     (cnt_hi),
        .cnt_lo_o     (cnt_lo),
        .ovf_evt_hi_o (ovf_hi_evt),
        .ovf_evt_lo_o (ovf_lo_evt),
        .cmp_evt_hi_o (cmp_hi_evt),
        .cmp_evt_lo_o (cmp_lo_evt)
    );

    always_comb set_evt = {cmp_lo_evt, ovf_lo_evt, cmp_hi_evt, ovf_hi_evt};

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        localparam int POS = flag_pos(i);
        dtt_flag_fsm u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_evt_i (set_evt[i]),
            .rd_i      (csr_rd),
            .wr_i      (csr_wr),
            .wbit_i    (bus_wdata_i[POS]),
            .flag_o    (flag[i])
        );
    end

    always_comb begin
        csr = {flag[0], flag[1], ovie_hi_q, cclr_hi_q,
               flag[2], flag[3], ovie_lo_q, cclr_lo_q};
        unique case (bus_addr_i)
            A_CSR:    bus_rdata_o = csr;
            A_CMP_HI: bus_rdata_o = cmp_hi_q;
            A_CMP_LO: bus_rdata_o = cmp_lo_q;
            A_CNT_HI: bus_rdata_o = cnt_hi;
            A_CNT_LO: bus_rdata_o = cnt_lo;
            default:  bus_rdata_o = '0;
        endcase
        irq_hi_o = flag[0] && ovie_hi_q;
        irq_lo_o = flag[2] && ovie_lo_q;
    end

    assert_enable_rw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |=> ({ovie_hi_q, cclr_hi_q, ovie_lo_q, cclr_lo_q} ==
                    $past({bus_wdata_i[B_OVIE_HI], bus_wdata_i[B_CCLR_HI],
                           bus_wdata_i[B_OVIE_LO], bus_wdata_i[B_CCLR_LO]})));

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag[0] && !flag[2]) |-> (!irq_hi_o && !irq_lo_o));
endmodule

// File: tb/dual_tick_timer_bench.sv
`timescale 1ns/100ps
module dual_tick_timer_bench;
    import dtt_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, mode = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic irq_hi, irq_lo;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model, built from the requirements
    logic [7:0] m_lo = 0, m_hi = 0, m_cmp_lo = 0, m_cmp_hi = 0;
    logic m_mode = 0, m_ovie_hi = 0, m_clr_hi = 0, m_ovie_lo = 0, m_clr_lo = 0;
    logic [3:0] m_f = 0, m_a = 0; // 0 ovf hi, 1 cmp hi, 2 ovf lo, 3 cmp lo

    always #2.5 clk = ~clk;

    dual_tick_timer u_dual_tick_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode),
        .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_hi_o(irq_hi), .irq_lo_o(irq_lo)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_csr();
        return {m_f[0], m_f[1], m_ovie_hi, m_clr_hi, m_f[2], m_f[3], m_ovie_lo, m_clr_lo};
    endfunction

    function automatic logic [7:0] en_byte();
        return {2'b00, m_ovie_hi, m_clr_hi, 2'b00, m_ovie_lo, m_clr_lo};
    endfunction

    task automatic model_tick();
        logic lh, hh, hm, lf, hf, cy;
        logic [7:0] nlo, nhi;
        lh = (m_lo == m_cmp_lo); hh = (m_hi == m_cmp_hi);
        hm = m_mode ? (lh && hh) : hh;
        lf = (m_lo == 8'hFF); hf = (m_hi == 8'hFF);
        cy = m_mode ? lf : 1'b1;
        if (cy && hf) m_f[0] = 1'b1;
        if (hm)       m_f[1] = 1'b1;
        if (lf)       m_f[2] = 1'b1;
        if (lh)       m_f[3] = 1'b1;
        nlo = (m_clr_lo && lh) ? 8'h00 : m_lo + 8'd1;
        nhi = cy ? m_hi + 8'd1 : m_hi;
        if (m_clr_hi && hm) begin
            nhi = 8'h00;
            if (m_mode) nlo = 8'h00;
        end
        m_lo = nlo; m_hi = nhi;
    endtask

    // called just after a falling edge
    task automatic run_ticks(input int n, input string tag, input bit per_tick);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            if (per_tick) begin
                addr = A_CNT_LO; #0.5; chk({tag, " low byte"}, {8'h00, rdata}, {8'h00, m_lo});
                addr = A_CNT_HI; #0.5; chk({tag, " high byte"}, {8'h00, rdata}, {8'h00, m_hi});
            end
            @(negedge clk);
            model_tick();
        end
        tick = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input bit t);
        logic [3:0] wb, mask;
        addr = a; wdata = d; wr = 1'b1; tick = t;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        wb = {d[2], d[3], d[6], d[7]};
        mask = (a == A_CSR) ? (m_a & ~wb) : 4'b0000;
        m_f = m_f & ~mask;
        if (t) model_tick();
        if (a == A_CSR) begin
            m_a = 4'b0000;
            m_ovie_hi = d[5]; m_clr_hi = d[4]; m_ovie_lo = d[1]; m_clr_lo = d[0];
        end
        if (a == A_CMP_HI) m_cmp_hi = d;
        if (a == A_CMP_LO) m_cmp_lo = d;
    endtask

    task automatic read_check(input logic [2:0] a, input logic [7:0] exp, input string tag);
        addr = a; rd = 1'b1; #1;
        chk(tag, {8'h00, rdata}, {8'h00, exp});
        if (a == A_CSR) begin
            chk({tag, " irq_hi (R9)"}, {15'd0, irq_hi}, {15'd0, m_f[0] & m_ovie_hi});
            chk({tag, " irq_lo (R9)"}, {15'd0, irq_lo}, {15'd0, m_f[2] & m_ovie_lo});
        end
        @(negedge clk);
        rd = 1'b0;
        if (a == A_CSR) m_a = m_a | m_f;
    endtask

    task automatic clear_flags();
        read_check(A_CSR, exp_csr(), "R6 pre-clear read");
        bus_write(A_CSR, en_byte(), 1'b0);
        chk("R6 model flags zero", {12'd0, m_f}, 16'd0);
        read_check(A_CSR, exp_csr(), "R6 after clear");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] tgt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values, R12 map
        for (int a = 0; a < 8; a++) read_check(3'(a), 8'h00, "R1 reset read");

        // R8 enable bits, writes of 1 to flags ignored
        bus_write(A_CSR, 8'hFF, 1'b0);
        read_check(A_CSR, 8'h33, "R8 enables set");
        bus_write(A_CSR, 8'h00, 1'b0);
        read_check(A_CSR, 8'h00, "R8 enables clear");

        // R12 compare registers
        bus_write(A_CMP_HI, 8'hC8, 1'b0);
        bus_write(A_CMP_LO, 8'hC8, 1'b0);
        read_check(A_CMP_HI, 8'hC8, "R12 compare high");
        read_check(A_CMP_LO, 8'hC8, "R12 compare low");
        read_check(3'd6, 8'h00, "R12 unused address");

        // R2 split counting, R4 R5 flags
        run_ticks(300, "R2 split", 1'b1);
        read_check(A_CNT_LO, 8'd44, "R2 low after 300");
        chk("R4 R5 all flags set", {8'h00, exp_csr()}, 16'h00CC);

        // R6 protocol
        bus_write(A_CSR, 8'h02, 1'b0);                   // 0 without read
        read_check(A_CSR, 8'hCE, "R6 unread write 0 no effect"); // arms all
        bus_write(A_CSR, 8'h42, 1'b0);                   // 1 on cmp hi keeps it
        bus_write(A_CSR, 8'h02, 1'b0);                   // arm used up
        read_check(A_CSR, 8'h42, "R6 write 1 and used-up arm");
        bus_write(A_CSR, 8'h02, 1'b0);
        read_check(A_CSR, 8'h02, "R6 clear after read");

        // R7 set beats clear
        bus_write(A_CMP_LO, m_lo, 1'b0);
        run_ticks(1, "R7 prep", 1'b1);
        bus_write(A_CMP_LO, m_lo + 8'd1, 1'b0);
        read_check(A_CSR, exp_csr(), "R7 arm read");
        run_ticks(1, "R7 prep", 1'b1);
        bus_write(A_CSR, 8'h02, 1'b1);
        chk("R7 model keeps flag", {15'd0, m_f[3]}, 16'd1);
        read_check(A_CSR, exp_csr(), "R7 set wins over clear");
        clear_flags();

        // R10 low clear-on-match sweep
        bus_write(A_CSR, 8'h01, 1'b0);
        foreach (tgt[k]) begin end
        for (int k = 0; k < 3; k++) begin
            bus_write(A_CMP_LO, (k == 0) ? 8'd3 : (k == 1) ? 8'd17 : 8'hFF, 1'b0);
            run_ticks(600, "R10 low clear", 1'b1);
            clear_flags();
        end

        // R11 split: high clears alone
        bus_write(A_CSR, 8'h10, 1'b0);
        bus_write(A_CMP_HI, 8'd40, 1'b0);
        run_ticks(600, "R11 split high clear", 1'b1);
        clear_flags();

        // R3 cascaded counting
        bus_write(A_CSR, 8'h00, 1'b0);
        mode = 1'b1; m_mode = 1'b1;
        run_ticks(600, "R3 cascade", 1'b1);
        clear_flags();

        // R11 cascaded: whole counter clears, R5 16-bit compare
        tgt = {m_hi, m_lo} + 16'h0105;
        bus_write(A_CMP_HI, tgt[15:8], 1'b0);
        bus_write(A_CMP_LO, tgt[7:0], 1'b0);
        bus_write(A_CSR, 8'h10, 1'b0);
        run_ticks(800, "R11 cascade clear", 1'b1);
        read_check(A_CSR, exp_csr(), "R5 cascade compare flags");
        clear_flags();

        // R4 16-bit rollover, R9 irq
        bus_write(A_CSR, 8'h20, 1'b0);
        run_ticks(65536, "R4 cascade wrap", 1'b0);
        chk("R4 model high overflow", {15'd0, m_f[0]}, 16'd1);
        read_check(A_CSR, exp_csr(), "R4 high overflow after wrap");
        read_check(A_CNT_HI, m_hi, "R3 high after wrap");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule